// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, for a small 32-bit RISC core, whether an exception or interrupt is entered in a given cycle. If one is entered, it produces everything the core needs to enter it. Requests arrive as a bit vector with one bit per cause. The block selects one cause by fixed priority and computes the handler address from one of two aligned base registers. In the following cycle it presents one-cycle write strobes:

- a load of the new program counter;
- a write of the interrupted PC into either the normal return-address register or the debug return-address register;
- an updated interrupt-enable register.

Causes split into two classes. Breakpoint and watchpoint form the debug class: they always use the debug base and the debug return register. System call, instruction bus fault, data bus fault, divide by zero and the external interrupt form the normal class. They use the normal return register and take their base from a remap control bit.

All pins are plain control and status; none carries a stream, so there is no back-pressure. Requesters hold their bit until they see their own bit in `ack`. The external interrupt is only taken while the global enable is set, so while the enable is clear it simply stays pending at the input. The core is expected to commit the strobed writes at the edge that ends the strobe cycle, so `ie_in` already reflects the cleared enable bit from the following cycle on.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, and whenever no cause is accepted, `pc_load`, `ea_we`, `ba_we`, `ie_we` and `ack` are all zero.
- R2: Cause indices are fixed as follows, and bit i of `exc_req` requests cause i:

  | Index | Cause |
  |---|---|
  | 0 | reset (never accepted) |
  | 1 | breakpoint |
  | 2 | instruction bus fault |
  | 3 | watchpoint |
  | 4 | data bus fault |
  | 5 | divide by zero |
  | 6 | external interrupt |
  | 7 | system call |

  A request with only bit 0 set causes no entry.
- R3: On an accepted cause with index k, `pc_next` equals the selected base plus k*32, and `cause` equals k.
- R4: Debug causes (1, 3) pulse `ba_we`. Normal causes (2, 4, 5, 6, 7) pulse `ea_we`. In both cases `ret_addr` equals the `cur_pc` that was sampled with the request.
- R5: Debug causes always take `deba` as base. Normal causes take `deba` when `remap_en` is 1 and `eba` otherwise.
- R6: On every entry `ie_we` pulses and `ie_next` bit 0 (global enable) is 0.
- R7: `ie_next` bit 1 (normal saved enable) is the old bit 1 ORed with the old bit 0 for a normal cause, and unchanged for a debug cause. Bit 2 (debug saved enable) is the old bit 2 ORed with the old bit 0 for a debug cause, and unchanged for a normal cause.
- R8: The external interrupt (bit 6) is accepted only while `ie_in` bit 0 is 1.
- R9: Among requests present together, the lowest index among 1, 2, 3, 4, 5 and 7 wins. The interrupt is chosen only if none of those is present.
- R10: All strobes, together with a one-hot `ack` naming the accepted cause, appear in the cycle after the request is sampled and last exactly one cycle. No request is accepted in a cycle in which strobes are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 8 | Request bits, one per cause index |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| ie_in | input | 3 | Current enable register: bit0 global, bit1 normal saved, bit2 debug saved |
| eba | input | 32 | Normal handler base, 256-byte aligned |
| deba | input | 32 | Debug handler base, 256-byte aligned |
| remap_en | input | 1 | Route normal causes to the debug base |
| pc_load | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 32 | Handler address |
| ea_we | output | 1 | Write `ret_addr` to the normal return register |
| ba_we | output | 1 | Write `ret_addr` to the debug return register |
| ret_addr | output | 32 | Interrupted PC |
| ie_we | output | 1 | Write `ie_next` to the enable register |
| ie_next | output | 3 | New enable register value |
| ack | output | 8 | One-hot accepted cause |
| cause | output | 3 | Index of the accepted cause |

## Verification
A wrong priority pick or class decode shows at the ports one cycle after the request. It appears as the wrong `ack` bit, the wrong return strobe, or a handler address in the wrong 32-byte slot or page. A stale or corrupted busy state shows as a second `pc_load` in the cycle right after an entry, or as a missing entry on the next request. A wrong enable update shows immediately in `ie_next` bit 0 or in the saved bit of the wrong class. The sweep covers every request pattern against every enable value and both remap settings, so each such fault reaches a checked strobe cycle within three clocks of its trigger.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN       = 32;
  localparam int NUM_CAUSE  = 8;
  localparam int IDX_W      = $clog2(NUM_CAUSE);
  localparam int SLOT_SHIFT = 5;
  localparam int IE_W       = 3;

  // enable register bit positions
  localparam int IE_GLB = 0;
  localparam int IE_NRM = 1;
  localparam int IE_DBG = 2;

  typedef enum logic [IDX_W-1:0] {
    C_RESET   = 3'd0,
    C_BRKPT   = 3'd1,
    C_IBUS    = 3'd2,
    C_WATCH   = 3'd3,
    C_DBUS    = 3'd4,
    C_DIVZ    = 3'd5,
    C_IRQ     = 3'd6,
    C_SYSCALL = 3'd7
  } cause_e;

  function automatic logic is_debug_cause(input logic [IDX_W-1:0] idx);
    return (idx == C_BRKPT) || (idx == C_WATCH);
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_entry_pkg::*;
#(
  parameter int N   = NUM_CAUSE,
  parameter int IW  = IDX_W,
  parameter int IRQ = 6
) (
  input  logic [N-1:0]  req,
  input  logic          irq_ok,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] fault_req;

  // Faults are every request except index 0 (reset) and the interrupt.
  for (genvar g = 0; g < N; g++) begin : g_mask
    if (g == 0 || g == IRQ) begin : g_off
      assign fault_req[g] = 1'b0;
    end else begin : g_on
      assign fault_req[g] = req[g];
    end
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    // Walk downwards so that the lowest set fault index remains.
    for (int i = N - 1; i >= 0; i--) begin
      if (fault_req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
    if (!hit && req[IRQ] && irq_ok) begin
      hit = 1'b1;
      idx = IW'(IRQ);
    end
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_entry_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IDX_W,
  parameter int SH = SLOT_SHIFT
) (
  input  logic [IW-1:0] idx,
  input  logic          dbg,
  input  logic          remap,
  input  logic [W-1:0]  base_nrm,
  input  logic [W-1:0]  base_dbg,
  output logic [W-1:0]  vec
);
  logic [W-1:0] base;
  logic [W-1:0] offset;

  always_comb begin
    base   = (dbg || remap) ? base_dbg : base_nrm;
    offset = W'(idx) << SH;
    vec    = base + offset;
  end
endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
  import exc_entry_pkg::*;
(
  input  logic [IE_W-1:0] ie_old,
  input  logic            dbg,
  output logic [IE_W-1:0] ie_new
);
  always_comb begin
    ie_new         = ie_old;
    ie_new[IE_GLB] = 1'b0;
    if (dbg) begin
      ie_new[IE_DBG] = ie_old[IE_DBG] | ie_old[IE_GLB];
    end else begin
      ie_new[IE_NRM] = ie_old[IE_NRM] | ie_old[IE_GLB];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] exc_req,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [IE_W-1:0]      ie_in,
  input  logic [XLEN-1:0]      eba,
  input  logic [XLEN-1:0]      deba,
  input  logic                 remap_en,
  output logic                 pc_load,
  output logic [XLEN-1:0]      pc_next,
  output logic                 ea_we,
  output logic                 ba_we,
  output logic [XLEN-1:0]      ret_addr,
  output logic                 ie_we,
  output logic [IE_W-1:0]      ie_next,
  output logic [NUM_CAUSE-1:0] ack,
  output logic [IDX_W-1:0]     cause
);
  logic                 sel_hit;
  logic [IDX_W-1:0]     sel_idx;
  logic                 sel_dbg;
  logic                 take;
  logic [XLEN-1:0]      vec_d;
  logic [IE_W-1:0]      ie_d;
  logic [NUM_CAUSE-1:0] ack_d;

  exc_prio_pick #(.N(NUM_CAUSE), .IW(IDX_W), .IRQ(int'(C_IRQ))) u_pick (
    .req    (exc_req),
    .irq_ok (ie_in[IE_GLB]),
    .hit    (sel_hit),
    .idx    (sel_idx)
  );

  assign sel_dbg = is_debug_cause(sel_idx);

  // While strobes are out, the enable register has not yet been written.
  assign take = sel_hit && !pc_load;

  exc_vector_calc #(.W(XLEN), .IW(IDX_W), .SH(SLOT_SHIFT)) u_vec (
    .idx      (sel_idx),
    .dbg      (sel_dbg),
    .remap    (remap_en),
    .base_nrm (eba),
    .base_dbg (deba),
    .vec      (vec_d)
  );

  exc_ie_update u_ie (
    .ie_old (ie_in),
    .dbg    (sel_dbg),
    .ie_new (ie_d)
  );

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_ack
    assign ack_d[g] = take && (sel_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load  <= 1'b0;
      ea_we    <= 1'b0;
      ba_we    <= 1'b0;
      ie_we    <= 1'b0;
      ack      <= '0;
      pc_next  <= '0;
      ret_addr <= '0;
      ie_next  <= '0;
      cause    <= '0;
    end else begin
      pc_load <= take;
      ea_we   <= take && !sel_dbg;
      ba_we   <= take && sel_dbg;
      ie_we   <= take;
      ack     <= ack_d;
      if (take) begin
        pc_next  <= vec_d;
        ret_addr <= cur_pc;
        ie_next  <= ie_d;
        cause    <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_entry_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CAUSE-1:0] exc_req,
  input logic [XLEN-1:0]      cur_pc,
  input logic [IE_W-1:0]      ie_in,
  input logic [XLEN-1:0]      eba,
  input logic [XLEN-1:0]      deba,
  input logic                 remap_en,
  input logic                 pc_load,
  input logic [XLEN-1:0]      pc_next,
  input logic                 ea_we,
  input logic                 ba_we,
  input logic [XLEN-1:0]      ret_addr,
  input logic                 ie_we,
  input logic [IE_W-1:0]      ie_next,
  input logic [NUM_CAUSE-1:0] ack,
  input logic [IDX_W-1:0]     cause
);
  p_one_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_we || ba_we) == pc_load && !(ea_we && ba_we));

  p_ret_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ret_addr == $past(cur_pc));

  p_dbg_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ba_we |-> pc_next[XLEN-1:8] == $past(deba[XLEN-1:8]));

  p_nrm_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we |-> pc_next[XLEN-1:8] ==
      ($past(remap_en) ? $past(deba[XLEN-1:8]) : $past(eba[XLEN-1:8])));

  p_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_next[7:0] == {cause, 5'b0}));

  p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ie_we |-> (pc_load && !ie_next[IE_GLB]));

  p_nrm_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we |-> (ie_next[IE_NRM] == ($past(ie_in[IE_NRM]) | $past(ie_in[IE_GLB])))
              && (ie_next[IE_DBG] == $past(ie_in[IE_DBG])));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == 8'h40 && !ie_in[IE_GLB]) |=> !pc_load);

  p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack) && ((ack != '0) == pc_load));

  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  p_no_reset_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == 8'h01) |=> !pc_load);
endmodule

bind exc_entry_ctrl exc_entry_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exc_req  (exc_req),
  .cur_pc   (cur_pc),
  .ie_in    (ie_in),
  .eba      (eba),
  .deba     (deba),
  .remap_en (remap_en),
  .pc_load  (pc_load),
  .pc_next  (pc_next),
  .ea_we    (ea_we),
  .ba_we    (ba_we),
  .ret_addr (ret_addr),
  .ie_we    (ie_we),
  .ie_next  (ie_next),
  .ack      (ack),
  .cause    (cause)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  exc_req = '0;
  logic [31:0] cur_pc = '0;
  logic [2:0]  ie_in = '0;
  logic [31:0] eba = '0;
  logic [31:0] deba = '0;
  logic        remap_en = 1'b0;
  logic        pc_load, ea_we, ba_we, ie_we;
  logic [31:0] pc_next, ret_addr;
  logic [2:0]  ie_next, cause;
  logic [7:0]  ack;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
    .ie_in(ie_in), .eba(eba), .deba(deba), .remap_en(remap_en),
    .pc_load(pc_load), .pc_next(pc_next), .ea_we(ea_we), .ba_we(ba_we),
    .ret_addr(ret_addr), .ie_we(ie_we), .ie_next(ie_next), .ack(ack),
    .cause(cause)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected pick: lowest fault index (1..5,7), else interrupt when enabled (R9, R8, R2).
  function automatic int exp_pick(input logic [7:0] r, input logic glb);
    for (int i = 1; i < 8; i++) begin
      if (i != 6 && r[i]) return i;
    end
    if (r[6] && glb) return 6;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!pc_load && !ea_we && !ba_we && !ie_we, "R1 strobes after reset",
        {28'd0, pc_load, ea_we, ba_we, ie_we}, 32'd0);
    chk(ack == 8'h00, "R1 ack after reset", {24'd0, ack}, 32'd0);

    t = 0;
    for (int rm = 0; rm < 2; rm++) begin
      for (int ie = 0; ie < 8; ie++) begin
        for (int rq = 0; rq < 256; rq++) begin
          int k;
          bit dbg;
          logic [31:0] base, pc_v, eb, db;
          logic [2:0] ie_e;
          t++;
          pc_v = 32'h1000_0000 + 32'(t) * 4;
          eb   = 32'h4000_0000 | ((32'(t) & 32'hFFF) << 8);
          db   = 32'h8000_0000 | (((32'(t) ^ 32'h5A5) & 32'hFFF) << 8);
          exc_req = 8'(rq); ie_in = 3'(ie); remap_en = rm[0];
          cur_pc = pc_v; eba = eb; deba = db;
          k = exp_pick(8'(rq), ie[0]);
          @(negedge clk);
          if (k < 0) begin
            // R1 no entry, R8 gated interrupt, R2 reset bit alone
            chk(!pc_load && !ea_we && !ba_we && !ie_we && ack == 0,
                (rq == 8'h40) ? "R8 gated irq" : (rq == 1 ? "R2 reset bit" : "R1 idle"),
                {pc_load, ea_we, ba_we, ie_we, 20'd0, ack}, 32'd0);
          end else begin
            dbg  = (k == 1 || k == 3);
            base = (dbg || rm == 1) ? db : eb;
            ie_e = 3'(ie);
            ie_e[0] = 1'b0;
            if (dbg) ie_e[2] = ie[2] | ie[0];
            else     ie_e[1] = ie[1] | ie[0];
            chk(pc_load, "R10 pc_load strobe", {31'd0, pc_load}, 32'd1);
            chk(cause == 3'(k), "R9 priority cause", {29'd0, cause}, 32'(k));
            chk(ack == (8'd1 << k), "R10 ack onehot", {24'd0, ack}, 32'd1 << k);
            chk(pc_next == base + 32'(k) * 32, "R3 R5 vector", pc_next, base + 32'(k) * 32);
            chk(ea_we == !dbg && ba_we == dbg, "R4 return strobe",
                {30'd0, ea_we, ba_we}, {30'd0, !dbg, dbg});
            chk(ret_addr == pc_v, "R4 return address", ret_addr, pc_v);
            chk(ie_we && ie_next[0] == 1'b0, "R6 enable cleared",
                {28'd0, ie_we, ie_next}, {28'd0, 1'b1, ie_e});
            chk(ie_next == ie_e, "R7 saved enable", {29'd0, ie_next}, {29'd0, ie_e});
          end
          // Request still held: no entry in the strobe cycle (R10)
          @(negedge clk);
          chk(!pc_load && ack == 0, "R10 single cycle",
              {23'd0, pc_load, ack}, 32'd0);
          exc_req = '0;
          @(negedge clk);
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule